// File: doc/BRIEF.md
# Converter Result Serial Output Port

This block moves one 24-bit conversion result off-chip over a single data line, most significant bit first. A result word arrives on a parallel bus together with a one-cycle valid pulse. It is captured only while the port is idle. Capturing it pulls the ready flag low, which tells the host that a word is waiting. An active-low chip select gates the output drivers. When the transfer is over, the ready flag returns high.

A static mode pin selects one of two clocking schemes. In master mode the port makes its own serial clock at half the master clock rate. Shifting starts a fixed number of master clocks after the select is seen low with a word pending. The ready flag rises a fixed number of master clocks after the last rising serial edge. In slave mode the host supplies the serial clock. That clock is synchronised into the master clock domain, and each of its falling edges moves the next bit onto the data line.

Top module: `ser_out_port`

## Requirements
- R1: After reset, rdy_o is 1 and sclk_o and sdo_o are 0.
- R2: A word is captured only when result_vld_i is 1 while rdy_o is 1. From the clk edge that captures it, rdy_o is 0 and sdo_o shows bit 23 of the word.
- R3: A valid pulse that arrives while rdy_o is 0 is ignored. The bits being sent are unchanged, and once rdy_o returns to 1 it stays at 1.
- R4: In master mode, the reference edge is the clk edge at which cs_n_i is first sampled 0 while a word is pending; this may be the capture edge itself. sclk_o stays 0 until it rises at the 8th clk edge after the reference edge.
- R5: In master mode, sclk_o toggles on every clk edge while shifting, so it runs at half the clk rate. It gives exactly 24 rising edges.
- R6: Bits leave MSB first. While sclk_o is high after its k-th rise (k = 0..23), sdo_o carries bit 23-k. sdo_o never changes on a rising sclk_o.
- R7: In master mode, rdy_o goes to 1 at the 8th clk edge after the edge of the final sclk_o rise. sdo_o is 0 from then on.
- R8: sdo_oe_o is 1 exactly when cs_n_i is 0. sclk_oe_o is 1 exactly when cs_n_i is 0 in master mode, and it is always 0 in slave mode.
- R9: sclk_o rests at 0 whenever rdy_o is 1, and while a pending word waits for its start.
- R10: In slave mode, each falling edge of sclk_i seen while cs_n_i is 0 moves the next bit onto sdo_o, three clk edges after the fall. Falls seen while cs_n_i is 1 shift nothing.
- R11: In slave mode, rdy_o goes to 1 on the 24th shifting fall. sdo_o then reads 0 for that fall and for every later fall until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | Static mode pin: 1 means the host clocks the port, 0 means the port makes its own clock |
| result_i | input | 24 | Parallel result word |
| result_vld_i | input | 1 | One-cycle valid pulse for result_i |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from the host (slave mode) |
| rdy_o | output | 1 | Ready flag; low while a captured word is waiting or being sent |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe_o | output | 1 | Output enable for sclk_o |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
Every result is counted in clk edges from a known stimulus edge. The capture, the ready fall and the MSB all appear on the capture edge. The first master rise comes 8 edges after the reference edge, every later rise 2 edges after the one before it, and the ready rise 8 edges after the final rise. A host clock fall shows up on sdo_o 3 edges after the line drops. The bench drives inputs only on falling clk edges and steps one falling edge at a time. It then samples just after the exact rising edge where each change is due, and checks the edge before it as well, so a result that comes one edge early or late is caught. Host clock phases are held for six cycles, which leaves room for the synchroniser delay.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ARMED,
    M_LEAD,
    M_SHIFT,
    M_TAIL
  } mst_state_t;

  // bits needed to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ser_out_edge.sv
module ser_out_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_evt
);
  // pipe[0..SYNC_STAGES-1] synchronise, pipe[SYNC_STAGES] keeps previous value
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-1:0], din};
  end

  assign fall_evt = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];
endmodule

// File: rtl/ser_out_shreg.sv
module ser_out_shreg
  import ser_out_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              adv,
  output logic              sdo,
  output logic              last_adv
);
  localparam int CW = cnt_width(WORD_W);
  localparam logic [CW-1:0] N_LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] N_FULL = CW'(WORD_W);

  logic [WORD_W-1:0] sr;
  logic [CW-1:0]     n_adv;

  // the advance that moves the LSB out ends the word
  assign last_adv = adv && (n_adv == N_LAST);
  assign sdo      = sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      n_adv <= '0;
    end else if (load) begin
      sr    <= din;
      n_adv <= '0;
    end else if (adv) begin
      sr <= {sr[WORD_W-2:0], 1'b0};
      if (n_adv != N_FULL) n_adv <= n_adv + 1'b1;
    end
  end
endmodule

// File: rtl/ser_out_mseq.sv
module ser_out_mseq
  import ser_out_pkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int TAIL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic cs_n,
  input  logic last_adv,
  output logic sclk,
  output logic fall_evt,
  output logic tail_done
);
  localparam int CW = cnt_width(max2(LEAD_CYC, TAIL_CYC));
  localparam logic [CW-1:0] LEAD_END = CW'(LEAD_CYC);
  localparam logic [CW-1:0] TAIL_END = CW'(TAIL_CYC);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] TWO      = CW'(2);

  mst_state_t    st;
  logic [CW-1:0] cnt;

  assign fall_evt  = (st == M_SHIFT) && sclk;
  assign tail_done = (st == M_TAIL) && (cnt == TAIL_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= M_IDLE;
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (en && load) begin
          cnt <= ONE;
          st  <= cs_n ? M_ARMED : M_LEAD;
        end
        M_ARMED: if (!cs_n) begin
          cnt <= ONE;
          st  <= M_LEAD;
        end
        M_LEAD: if (cnt == LEAD_END) begin
          sclk <= 1'b1;
          st   <= M_SHIFT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        M_SHIFT: if (sclk) begin
          sclk <= 1'b0;
          if (last_adv) begin
            st  <= M_TAIL;
            cnt <= TWO;
          end
        end else begin
          sclk <= 1'b1;
        end
        M_TAIL: if (tail_done) st <= M_IDLE;
                else           cnt <= cnt + 1'b1;
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_out_port.sv
module ser_out_port
  import ser_out_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int LEAD_CYC    = 8,
  parameter int TAIL_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic [WORD_W-1:0] result_i,
  input  logic              result_vld_i,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  output logic              rdy_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic rdy_q;
  logic load_evt;
  logic host_fall;
  logic host_adv;
  logic mst_fall;
  logic shift_adv;
  logic last_adv;
  logic tail_done;
  logic xfer_done;
  logic mst_sclk;

  assign load_evt  = result_vld_i & rdy_q;
  assign host_adv  = slave_mode & host_fall & ~cs_n_i;
  assign shift_adv = slave_mode ? host_adv : mst_fall;
  assign xfer_done = slave_mode ? last_adv : tail_done;

  ser_out_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (sclk_i),
    .fall_evt (host_fall)
  );

  ser_out_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .din      (result_i),
    .adv      (shift_adv),
    .sdo      (sdo_o),
    .last_adv (last_adv)
  );

  ser_out_mseq #(.LEAD_CYC(LEAD_CYC), .TAIL_CYC(TAIL_CYC)) u_mseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (~slave_mode),
    .load      (load_evt),
    .cs_n      (cs_n_i),
    .last_adv  (last_adv),
    .sclk      (mst_sclk),
    .fall_evt  (mst_fall),
    .tail_done (tail_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdy_q <= 1'b1;
    else if (load_evt)  rdy_q <= 1'b0;
    else if (xfer_done) rdy_q <= 1'b1;
  end

  assign rdy_o     = rdy_q;
  assign sclk_o    = mst_sclk;
  assign sclk_oe_o = ~slave_mode & ~cs_n_i;
  assign sdo_oe_o  = ~cs_n_i;
endmodule

// File: rtl/ser_out_port_chk.sv
module ser_out_port_chk (
  input logic clk,
  input logic rst_n,
  input logic slave_mode,
  input logic result_vld_i,
  input logic rdy_o,
  input logic sclk_o,
  input logic sdo_o
);
  // R2
  rdy_fall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(result_vld_i));

  // R5
  sclk_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && sclk_o) |=> !sclk_o);

  // R6
  sdo_hold_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $rose(sclk_o)) |-> $stable(sdo_o));

  // R9
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> !sclk_o);

  // R7
  tail_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $rose(rdy_o)) |-> ($past(sclk_o, 8) && !$past(sclk_o, 7)));

  // R11
  drained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> !sdo_o);
endmodule

bind ser_out_port ser_out_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_mode   (slave_mode),
  .result_vld_i (result_vld_i),
  .rdy_o        (rdy_o),
  .sclk_o       (sclk_o),
  .sdo_o        (sdo_o)
);

// File: tb/sim_ser_out_port.sv
module sim_ser_out_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 1'b0;
  logic [23:0] result_i = '0;
  logic        result_vld_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        sclk_i = 1'b0;
  logic        rdy_o, sclk_o, sclk_oe_o, sdo_o, sdo_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ser_out_port u0 (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .result_i(result_i), .result_vld_i(result_vld_i),
    .cs_n_i(cs_n_i), .sclk_i(sclk_i),
    .rdy_o(rdy_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    slave_mode   = mode;
    cs_n_i       = 1'b1;
    result_vld_i = 1'b0;
    sclk_i       = 1'b0;
    rst_n        = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // leaves the bench at the falling edge just after the capture edge
  task automatic load_word(input logic [23:0] d);
    result_i     = d;
    result_vld_i = 1'b1;
    @(negedge clk);
    result_vld_i = 1'b0;
  endtask

  // entry: falling edge just after the reference edge E0
  task automatic master_frame(input logic [23:0] d, input logic [23:0] junk, input bit inject);
    for (int e = 1; e < 8; e++) begin
      @(negedge clk);
      chk("R4 sclk low during lead", sclk_o, 1'b0);
    end
    @(negedge clk);
    chk("R4 first sclk rise", sclk_o, 1'b1);
    chk("R6 msb at first rise", sdo_o, d[23]);
    for (int k = 1; k < 24; k++) begin
      if (inject && k == 5) begin
        result_i     = junk;
        result_vld_i = 1'b1;
      end
      @(negedge clk);
      result_vld_i = 1'b0;
      chk("R5 sclk low phase", sclk_o, 1'b0);
      @(negedge clk);
      chk("R5 sclk high phase", sclk_o, 1'b1);
      chk(inject ? "R3 bit kept after dropped word" : "R6 data bit", sdo_o, d[23-k]);
    end
    for (int t = 1; t < 8; t++) begin
      @(negedge clk);
      chk("R7 rdy still low in tail", rdy_o, 1'b0);
      chk("R9 sclk rests low in tail", sclk_o, 1'b0);
    end
    @(negedge clk);
    chk("R7 rdy high after tail", rdy_o, 1'b1);
    chk("R7 sdo zero after frame", sdo_o, 1'b0);
    repeat (10) @(negedge clk);
    chk(inject ? "R3 no reload from dropped word" : "R9 idle rdy", rdy_o, 1'b1);
    chk("R9 idle sclk low", sclk_o, 1'b0);
  endtask

  task automatic host_clock();
    sclk_i = 1'b1;
    repeat (6) @(negedge clk);
    sclk_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset(1'b0);
    chk("R1 rdy after reset", rdy_o, 1'b1);
    chk("R1 sclk after reset", sclk_o, 1'b0);
    chk("R1 sdo after reset", sdo_o, 1'b0);
    chk("R8 sdo_oe with cs high", sdo_oe_o, 1'b0);
    chk("R8 sclk_oe with cs high", sclk_oe_o, 1'b0);
  endtask

  task automatic test_master_cs_low(input logic [23:0] d);
    do_reset(1'b0);
    cs_n_i = 1'b0;
    @(negedge clk);
    chk("R8 sdo_oe with cs low", sdo_oe_o, 1'b1);
    chk("R8 sclk_oe master cs low", sclk_oe_o, 1'b1);
    load_word(d);
    chk("R2 rdy falls on capture", rdy_o, 1'b0);
    chk("R2 msb on capture", sdo_o, d[23]);
    master_frame(d, 24'h0, 1'b0);
  endtask

  task automatic test_master_cs_late(input logic [23:0] d);
    do_reset(1'b0);
    load_word(d);
    chk("R2 rdy falls with cs high", rdy_o, 1'b0);
    chk("R8 sdo_oe off while cs high", sdo_oe_o, 1'b0);
    chk("R8 sclk_oe off while cs high", sclk_oe_o, 1'b0);
    repeat (12) begin
      @(negedge clk);
      chk("R9 sclk waits for select", sclk_o, 1'b0);
    end
    cs_n_i = 1'b0;
    @(negedge clk);
    master_frame(d, 24'h0, 1'b0);
  endtask

  task automatic test_master_drop(input logic [23:0] d, input logic [23:0] junk);
    do_reset(1'b0);
    cs_n_i = 1'b0;
    load_word(d);
    chk("R2 msb before drop", sdo_o, d[23]);
    master_frame(d, junk, 1'b1);
  endtask

  task automatic test_slave(input logic [23:0] d);
    do_reset(1'b1);
    cs_n_i = 1'b0;
    load_word(d);
    chk("R2 rdy low slave", rdy_o, 1'b0);
    chk("R2 msb slave", sdo_o, d[23]);
    chk("R8 sclk_oe off in slave", sclk_oe_o, 1'b0);
    chk("R8 sdo_oe on in slave", sdo_oe_o, 1'b1);
    for (int k = 1; k <= 24; k++) begin
      host_clock();
      if (k < 24) begin
        chk("R10 slave bit", sdo_o, d[23-k]);
        chk("R10 rdy low mid word", rdy_o, 1'b0);
        chk("R9 no generated sclk in slave", sclk_o, 1'b0);
      end else begin
        chk("R11 rdy high after 24th fall", rdy_o, 1'b1);
        chk("R11 sdo zero after 24th fall", sdo_o, 1'b0);
      end
      if (k == 11) begin
        cs_n_i = 1'b1;
        @(negedge clk);
        chk("R8 sdo_oe off mid word", sdo_oe_o, 1'b0);
        host_clock();
        cs_n_i = 1'b0;
        @(negedge clk);
        chk("R10 no shift while deselected", sdo_o, d[12]);
      end
    end
    host_clock();
    chk("R11 zeros after word", sdo_o, 1'b0);
    chk("R11 rdy stays high", rdy_o, 1'b1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_master_cs_low(24'hA5_3C_96);
    test_master_cs_late(24'h81_7E_42);
    test_master_drop(24'hC3_0F_F1, 24'h3C_F0_0E);
    test_slave(24'hB4_D2_69);
    test_slave(24'h80_00_01);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule